// File: doc/BRIEF.md
# Real-Mode Address Generator with Bit-20 Gate

This block forms the physical address of a real-mode processor whose external address bus is 24 bits wide. It takes a 16-bit segment and a 16-bit offset and adds the segment, shifted four places left, to the offset. The sum is 21 bits wide, so an address near the top of the first megabyte can carry into bit 20. A gate on bit 20 decides what happens to that carry. When the gate is closed, bit 20 is forced to zero and the address wraps to the bottom of memory, as it does on older 20-bit machines. When the gate is open, the carry reaches the first 64 KB of extended memory, which is called the high memory area.

The gate is open when either of two sources asks for it. The first is the protected-mode input. The second is an enable bit held in a register that software can write. Real-mode code can therefore open the gate without changing mode. The address leaves the block through a register, together with a flag that is set when the access falls inside the high memory area.

Top module: `real_addr_gen`

## Requirements
- R1: The output address equals segment*16 + offset, computed to 21 bits. It appears on `addr_o` one clock edge after the inputs are sampled.
- R2: With the gate open, segment FFFF and offset FFFF give `addr_o` = 10FFEF hex.
- R3: With the gate closed, bit 20 of `addr_o` is forced to zero, so FFFF:FFFF gives 00FFEF hex and FFFF:0010 gives 000000.
- R4: Bits 23 to 21 of `addr_o` are always zero.
- R5: `hma_hit_o` is 1 exactly when the registered address lies in 100000..10FFEF hex. Because a closed gate clears bit 20, the flag can only be set while the gate is open.
- R6: While `rst_ni` is low, `addr_o` is 0, `hma_hit_o` is 0 and the software enable bit is cleared. After reset the gate stays closed until a source opens it.
- R7: `prot_mode_i` = 1 opens the gate for the address sampled on that edge.
- R8: A clock edge with `gate_wr_i` = 1 loads `gate_wdata_i` into the software enable bit. The new value first affects the address sampled on the following edge.
- R9: The effective gate is the OR of `prot_mode_i` and the software enable bit. Clearing the software bit while in protected mode leaves the gate open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seg_i | input | 16 | Segment value |
| off_i | input | 16 | Offset value |
| prot_mode_i | input | 1 | 1 = protected mode, which opens the gate |
| gate_wr_i | input | 1 | Write strobe for the software enable bit |
| gate_wdata_i | input | 1 | Value written to the software enable bit |
| addr_o | output | 24 | Registered physical address after the gate |
| hma_hit_o | output | 1 | Registered flag: the address is in the high memory area |

## Verification
The bench builds the block with its default widths: a 16-bit segment and offset, a shift of 4 and a 24-bit bus. At these widths the largest sum, FFFF:FFFF, lands exactly on the last byte of the high memory area. This brings both ends of the high-memory range and the wrap of that byte to 00FFEF within reach. The test table also covers the edges just below the range (0FFFFF), the first byte of the range (FFFF:0010) and an address in the middle of the range. Directed sequences time a software write against the address it first affects. Another sequence checks that the enable bit comes back cleared after a mid-run reset.

// File: rtl/ra_pkg.sv
package ra_pkg;
  localparam int unsigned SEG_W_DEF = 16;
  localparam int unsigned OFF_W_DEF = 16;
  localparam int unsigned SHIFT_DEF = 4;
  localparam int unsigned BUS_W_DEF = 24;

  function automatic int unsigned sum_width(int unsigned seg_w, int unsigned shift,
                                            int unsigned off_w);
    int unsigned a;
    a = seg_w + shift;
    return ((a > off_w) ? a : off_w) + 1;
  endfunction

  // highest address reachable from segment:offset
  function automatic int unsigned sum_max(int unsigned seg_w, int unsigned shift,
                                          int unsigned off_w);
    return ((((32'd1 << seg_w) - 1) << shift) + ((32'd1 << off_w) - 1));
  endfunction
endpackage

// File: rtl/ra_lin_sum.sv
module ra_lin_sum #(
  parameter int unsigned SEG_W = 16,
  parameter int unsigned OFF_W = 16,
  parameter int unsigned SHIFT = 4,
  parameter int unsigned LIN_W = 21
) (
  input  logic [SEG_W-1:0] seg_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [LIN_W-1:0] lin_o
);
  localparam int unsigned SH_W = SEG_W + SHIFT;

  logic [SH_W-1:0] seg_sh;

  assign seg_sh = {seg_i, {SHIFT{1'b0}}};
  assign lin_o  = LIN_W'(seg_sh) + LIN_W'(off_i);
endmodule

// File: rtl/ra_gate_ctrl.sv
module ra_gate_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic prot_mode_i,
  input  logic gate_wr_i,
  input  logic gate_wdata_i,
  output logic sw_en_o,
  output logic gate_o
);
  logic sw_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sw_en_q <= 1'b0;
    else if (gate_wr_i) sw_en_q <= gate_wdata_i;
  end

  assign sw_en_o = sw_en_q;
  assign gate_o  = prot_mode_i | sw_en_q;
endmodule

// File: rtl/ra_addr_mask.sv
module ra_addr_mask #(
  parameter int unsigned LIN_W    = 21,
  parameter int unsigned BUS_W    = 24,
  parameter int unsigned GATE_BIT = 20,
  parameter logic [BUS_W-1:0] HMA_LO = 24'h100000,
  parameter logic [BUS_W-1:0] HMA_HI = 24'h10FFEF
) (
  input  logic [LIN_W-1:0] lin_i,
  input  logic             gate_i,
  output logic [BUS_W-1:0] addr_o,
  output logic             hma_o
);
  for (genvar i = 0; i < BUS_W; i++) begin : g_bit
    if (i >= LIN_W) begin : g_zero
      assign addr_o[i] = 1'b0;
    end else if (i == GATE_BIT) begin : g_gate
      assign addr_o[i] = lin_i[i] & gate_i;
    end else begin : g_pass
      assign addr_o[i] = lin_i[i];
    end
  end

  assign hma_o = (addr_o >= HMA_LO) && (addr_o <= HMA_HI);
endmodule

// File: rtl/real_addr_gen.sv
module real_addr_gen #(
  parameter int unsigned SEG_W = ra_pkg::SEG_W_DEF,
  parameter int unsigned OFF_W = ra_pkg::OFF_W_DEF,
  parameter int unsigned SHIFT = ra_pkg::SHIFT_DEF,
  parameter int unsigned BUS_W = ra_pkg::BUS_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEG_W-1:0] seg_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic             prot_mode_i,
  input  logic             gate_wr_i,
  input  logic             gate_wdata_i,
  output logic [BUS_W-1:0] addr_o,
  output logic             hma_hit_o
);
  localparam int unsigned LIN_W    = ra_pkg::sum_width(SEG_W, SHIFT, OFF_W);
  localparam int unsigned GATE_BIT = LIN_W - 1;
  localparam logic [BUS_W-1:0] HMA_LO = BUS_W'(1) << GATE_BIT;
  localparam logic [BUS_W-1:0] HMA_HI = BUS_W'(ra_pkg::sum_max(SEG_W, SHIFT, OFF_W));

  logic [LIN_W-1:0] lin;
  logic             gate;
  logic             sw_en_q;
  logic [BUS_W-1:0] addr_d;
  logic             hma_d;

  ra_lin_sum #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .LIN_W(LIN_W)) u_sum (
    .seg_i (seg_i),
    .off_i (off_i),
    .lin_o (lin)
  );

  ra_gate_ctrl u_gate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .prot_mode_i  (prot_mode_i),
    .gate_wr_i    (gate_wr_i),
    .gate_wdata_i (gate_wdata_i),
    .sw_en_o      (sw_en_q),
    .gate_o       (gate)
  );

  ra_addr_mask #(
    .LIN_W(LIN_W), .BUS_W(BUS_W), .GATE_BIT(GATE_BIT),
    .HMA_LO(HMA_LO), .HMA_HI(HMA_HI)
  ) u_mask (
    .lin_i  (lin),
    .gate_i (gate),
    .addr_o (addr_d),
    .hma_o  (hma_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o    <= '0;
      hma_hit_o <= 1'b0;
    end else begin
      addr_o    <= addr_d;
      hma_hit_o <= hma_d;
    end
  end
endmodule

// File: rtl/ra_checker.sv
module ra_checker #(
  parameter int unsigned SEG_W    = 16,
  parameter int unsigned OFF_W    = 16,
  parameter int unsigned SHIFT    = 4,
  parameter int unsigned BUS_W    = 24,
  parameter int unsigned LIN_W    = 21,
  parameter int unsigned GATE_BIT = 20,
  parameter logic [BUS_W-1:0] HMA_LO = 24'h100000,
  parameter logic [BUS_W-1:0] HMA_HI = 24'h10FFEF
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [SEG_W-1:0] seg_i,
  input logic [OFF_W-1:0] off_i,
  input logic             prot_mode_i,
  input logic             gate_wr_i,
  input logic             gate_wdata_i,
  input logic             sw_en_q,
  input logic [BUS_W-1:0] addr_o,
  input logic             hma_hit_o
);
  localparam int unsigned LOW_W = LIN_W - 1;

  logic [LIN_W-1:0] ref_sum;
  assign ref_sum = (LIN_W'(seg_i) << SHIFT) + LIN_W'(off_i);

  a_r1_low_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> addr_o[LOW_W-1:0] == $past(ref_sum[LOW_W-1:0]));

  a_r3_closed_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!prot_mode_i && !sw_en_q) |=> !addr_o[GATE_BIT]);

  a_r4_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_o >> LIN_W) == '0);

  a_r5_hit_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hma_hit_o |-> (addr_o >= HMA_LO && addr_o <= HMA_HI));

  a_r5_bit20_hits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_o[GATE_BIT] |-> hma_hit_o);

  a_r8_sw_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_wr_i |=> sw_en_q == $past(gate_wdata_i));

  a_r9_pm_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prot_mode_i && ref_sum[GATE_BIT]) |=> addr_o[GATE_BIT]);
endmodule

bind real_addr_gen ra_checker #(
  .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .BUS_W(BUS_W),
  .LIN_W(LIN_W), .GATE_BIT(GATE_BIT), .HMA_LO(HMA_LO), .HMA_HI(HMA_HI)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .seg_i        (seg_i),
  .off_i        (off_i),
  .prot_mode_i  (prot_mode_i),
  .gate_wr_i    (gate_wr_i),
  .gate_wdata_i (gate_wdata_i),
  .sw_en_q      (sw_en_q),
  .addr_o       (addr_o),
  .hma_hit_o    (hma_hit_o)
);

// File: tb/tb_real_addr_gen.sv
module tb_real_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] seg = '0;
  logic [15:0] off = '0;
  logic        pm = 1'b0;
  logic        wr = 1'b0;
  logic        wdata = 1'b0;
  logic [23:0] addr;
  logic        hit;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  real_addr_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .seg_i(seg), .off_i(off),
    .prot_mode_i(pm), .gate_wr_i(wr), .gate_wdata_i(wdata),
    .addr_o(addr), .hma_hit_o(hit)
  );

  // {seg, off, prot_mode, expected addr, expected hit}
  localparam logic [57:0] VEC [12] = '{
    {16'h0000, 16'h0000, 1'b0, 24'h000000, 1'b0},
    {16'h1234, 16'h5678, 1'b0, 24'h0179B8, 1'b0},
    {16'hFFFF, 16'hFFFF, 1'b0, 24'h00FFEF, 1'b0},
    {16'hFFFF, 16'hFFFF, 1'b1, 24'h10FFEF, 1'b1},
    {16'hFFFF, 16'h0010, 1'b1, 24'h100000, 1'b1},
    {16'hFFFF, 16'h000F, 1'b1, 24'h0FFFFF, 1'b0},
    {16'hF000, 16'hFFFF, 1'b1, 24'h0FFFFF, 1'b0},
    {16'hFFFF, 16'h0010, 1'b0, 24'h000000, 1'b0},
    {16'hA000, 16'h8000, 1'b1, 24'h0A8000, 1'b0},
    {16'h1000, 16'h0100, 1'b1, 24'h010100, 1'b0},
    {16'hF800, 16'hFFF0, 1'b1, 24'h107FF0, 1'b1},
    {16'hF800, 16'hFFF0, 1'b0, 24'h007FF0, 1'b0}
  };

  task automatic chk(input string req, input logic [23:0] ea, input logic eh);
    checks++;
    if (addr !== ea || hit !== eh) begin
      errors++;
      $display("FAIL %s: addr=%h hit=%b expected addr=%h hit=%b", req, addr, hit, ea, eh);
    end
  endtask

  // drive at negedge, register at posedge, sample at next negedge
  task automatic step(input logic [15:0] s, input logic [15:0] o, input logic p,
                      input logic w, input logic d);
    seg = s; off = o; pm = p; wr = w; wdata = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    seg = 16'hFFFF; off = 16'hFFFF; pm = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 reset state", 24'h0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4 R5 R7 table walk
    foreach (VEC[i]) begin
      step(VEC[i][57:42], VEC[i][41:26], VEC[i][25], 1'b0, 1'b0);
      chk($sformatf("R1/R2/R3/R4/R5/R7 vec %0d", i), VEC[i][24:1], VEC[i][0]);
    end

    // R8: software write, effective one edge later
    step(16'hFFFF, 16'hFFFF, 1'b0, 1'b1, 1'b1);
    chk("R8 write edge uses old enable", 24'h00FFEF, 1'b0);
    step(16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b0);
    chk("R8 sw enable opens gate", 24'h10FFEF, 1'b1);
    step(16'hFFFF, 16'h0010, 1'b0, 1'b0, 1'b1);
    chk("R5 hma low edge via sw enable", 24'h100000, 1'b1);
    // R9: OR of the two sources
    step(16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 1'b0);
    chk("R9 both sources", 24'h10FFEF, 1'b1);
    step(16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 1'b0);
    chk("R9 pm keeps gate open with sw cleared", 24'h10FFEF, 1'b1);
    step(16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b0);
    chk("R8 sw cleared closes gate", 24'h00FFEF, 1'b0);

    // R6: mid-run reset clears software enable
    step(16'hFFFF, 16'hFFFF, 1'b0, 1'b1, 1'b1);
    step(16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b0);
    chk("R8 sw set before reset", 24'h10FFEF, 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R6 outputs cleared in reset", 24'h0, 1'b0);
    rst_n = 1'b1;
    step(16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b0);
    chk("R6 gate closed after reset", 24'h00FFEF, 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: addr=%h hit=%b expected completion", addr, hit);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule